// File: doc/BRIEF.md
# Five-Valued Test Cube Merger

This block combines two partial test cubes during path-sensitizing test generation. A cube assigns one value to each of `LINES` circuit lines. Each value is one of five: logic 0, logic 1, unspecified (X), fault-carrying D (1 in the good machine, 0 in the faulty one) and its complement D-bar (0 in the good machine, 1 in the faulty one). When `start` is high, the block samples both cubes and merges them one line at a time. One cycle later it presents the merged cube, a pulse on `out_valid`, and two failure flags.

The two flags report different kinds of failure. `hard_fail` marks a real contradiction: a 0 meets a 1, or an input carries an undefined code. A search engine drops such a candidate. `soft_fail` marks a clash in which D or D-bar meets a different specified value. Another choice of propagation cube might still succeed in that case, so the surrounding search can choose to retry.

Control is a two-state machine. `IDLE` waits and keeps `out_valid` low. The transition `IDLE -> PRESENT` is taken on `start`. `PRESENT` drives `out_valid` high for that cycle. The transition `PRESENT -> PRESENT` is taken on a back-to-back `start`, and `PRESENT -> IDLE` is taken otherwise. Reset forces `IDLE`.

Top module: `cube_intersect_unit`

## Requirements
- R1: Line i occupies bits [3i+2:3i] of each cube bus, coded 000=0, 001=1, 010=X, 011=D, 100=D-bar. X merged with any defined value gives that other value, with no flag.
- R2: Two equal defined values merge to that same value, with no flag.
- R3: A 0 meeting a 1 on any line, in either order, sets `hard_fail`.
- R4: D or D-bar meeting a different value other than X (0, 1, or the opposite fault value) sets `soft_fail` and does not set `hard_fail` for that line.
- R5: Any code 101, 110 or 111 on either input line sets `hard_fail`.
- R6: The flags cover the whole cube. A single failing line raises its flag, and a cube that holds both kinds of clash raises both flags. `cube_out` is meaningful only when both flags are low.
- R7: `cube_out` and both flags update on the clock edge that samples `start` high, and `out_valid` is high for exactly that following cycle. Without `start`, the outputs hold their values and `out_valid` stays low.
- R8: A synchronous active-high `rst` clears `out_valid`, `hard_fail` and `soft_fail`.
- R9: Starts on consecutive cycles each produce their own result, with `out_valid` staying high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Sample and merge the two cubes |
| cube_a | input | 3*LINES | First cube, 3 bits per line |
| cube_b | input | 3*LINES | Second cube, 3 bits per line |
| cube_out | output | 3*LINES | Merged cube (registered) |
| hard_fail | output | 1 | 0/1 contradiction or undefined code |
| soft_fail | output | 1 | Fault-value clash |
| out_valid | output | 1 | One-cycle result strobe |

## Verification
All 25 ordered pairs of defined values are applied on a single line, with every other line left unspecified. This separates the identity, equality, hard-clash and soft-clash rules without interference from other lines. Directed cubes then place undefined codes, a single clash on the top line, and mixed hard and soft clashes in one cube, to show that the flags cover the whole cube and are reported independently. Seeded random cubes are built from a base cube with X and occasional clashes substituted in. These exercise every line position at once, and idle gaps and back-to-back starts check the strobe and hold timing.

// File: rtl/cube_pkg.sv
package cube_pkg;
    localparam int LINE_W = 3;

    typedef enum logic [LINE_W-1:0] {
        LV_ZERO = 3'b000,
        LV_ONE  = 3'b001,
        LV_X    = 3'b010,
        LV_D    = 3'b011,
        LV_DBAR = 3'b100
    } line_val_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } ctrl_state_e;

    function automatic logic code_defined(input logic [LINE_W-1:0] c);
        return c <= LV_DBAR;
    endfunction

    function automatic logic code_is_fault(input logic [LINE_W-1:0] c);
        return (c == LV_D) || (c == LV_DBAR);
    endfunction
endpackage

// File: rtl/cube_line_merge.sv
module cube_line_merge
    import cube_pkg::*;
(
    input  logic [LINE_W-1:0] val_a,
    input  logic [LINE_W-1:0] val_b,
    output logic [LINE_W-1:0] val_r,
    output logic              clash_hard,
    output logic              clash_soft
);
    always_comb begin
        val_r      = LV_X;
        clash_hard = 1'b0;
        clash_soft = 1'b0;
        if (!code_defined(val_a) || !code_defined(val_b)) begin
            clash_hard = 1'b1;
        end else if (val_a == LV_X) begin
            val_r = val_b;
        end else if (val_b == LV_X) begin
            val_r = val_a;
        end else if (val_a == val_b) begin
            val_r = val_a;
        end else if (code_is_fault(val_a) || code_is_fault(val_b)) begin
            clash_soft = 1'b1;
        end else begin
            clash_hard = 1'b1;
        end
    end

    // A single line reports at most one kind of failure (R4)
    always_comb begin
        assert_line_exclusive_R4: assert (!(clash_hard && clash_soft));
    end
endmodule

// File: rtl/cube_merge_core.sv
module cube_merge_core
    import cube_pkg::*;
#(
    parameter int LINES = 12,
    localparam int BUS_W = LINES * LINE_W
) (
    input  logic [BUS_W-1:0] bus_a,
    input  logic [BUS_W-1:0] bus_b,
    output logic [BUS_W-1:0] bus_r,
    output logic             any_hard,
    output logic             any_soft
);
    logic [LINES-1:0] hard_vec;
    logic [LINES-1:0] soft_vec;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        cube_line_merge u_line (
            .val_a      (bus_a[i*LINE_W +: LINE_W]),
            .val_b      (bus_b[i*LINE_W +: LINE_W]),
            .val_r      (bus_r[i*LINE_W +: LINE_W]),
            .clash_hard (hard_vec[i]),
            .clash_soft (soft_vec[i])
        );
    end

    assign any_hard = |hard_vec;
    assign any_soft = |soft_vec;
endmodule

// File: rtl/cube_intersect_unit.sv
module cube_intersect_unit
    import cube_pkg::*;
#(
    parameter int LINES = 12,
    localparam int BUS_W = LINES * LINE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [BUS_W-1:0] cube_a,
    input  logic [BUS_W-1:0] cube_b,
    output logic [BUS_W-1:0] cube_out,
    output logic             hard_fail,
    output logic             soft_fail,
    output logic             out_valid
);
    ctrl_state_e      state_q;
    ctrl_state_e      state_d;
    logic [BUS_W-1:0] merged;
    logic             merged_hard;
    logic             merged_soft;

    cube_merge_core #(.LINES(LINES)) u_core (
        .bus_a    (cube_a),
        .bus_b    (cube_b),
        .bus_r    (merged),
        .any_hard (merged_hard),
        .any_soft (merged_soft)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE:    state_d = start ? ST_PRESENT : ST_IDLE;
            ST_PRESENT: state_d = start ? ST_PRESENT : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cube_out  <= '0;
            hard_fail <= 1'b0;
            soft_fail <= 1'b0;
        end else if (start) begin
            cube_out  <= merged;
            hard_fail <= merged_hard;
            soft_fail <= merged_soft;
        end
    end

    assign out_valid = (state_q == ST_PRESENT);

    assert_valid_after_start_R7: assert property (@(posedge clk) disable iff (rst)
        start |=> out_valid);
    assert_no_valid_without_start_R7: assert property (@(posedge clk) disable iff (rst)
        !start |=> !out_valid);
    assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(hard_fail) && $stable(soft_fail) && $stable(cube_out)));
    assert_reset_clears_R8: assert property (@(posedge clk)
        rst |=> (!out_valid && !hard_fail && !soft_fail));
endmodule

// File: tb/cube_intersect_unit_test.sv
module cube_intersect_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int LINES = 12;
    localparam int BW = 3 * LINES;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [BW-1:0] cube_a = '0;
    logic [BW-1:0] cube_b = '0;
    logic [BW-1:0] cube_out;
    logic          hard_fail, soft_fail, out_valid;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    cube_intersect_unit #(.LINES(LINES)) uut (
        .clk(clk), .rst(rst), .start(start), .cube_a(cube_a), .cube_b(cube_b),
        .cube_out(cube_out), .hard_fail(hard_fail), .soft_fail(soft_fail),
        .out_valid(out_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference per-line rule, written from the requirements
    function automatic void ref_line(input logic [2:0] a, input logic [2:0] b,
                                     output logic [2:0] r, output logic h, output logic s);
        r = 3'b010; h = 0; s = 0;
        if (a > 3'd4 || b > 3'd4) h = 1;
        else if (a == 3'b010) r = b;
        else if (b == 3'b010) r = a;
        else if (a == b) r = a;
        else if (a >= 3'd3 || b >= 3'd3) s = 1;
        else h = 1;
    endfunction

    function automatic void ref_cube(input logic [BW-1:0] a, input logic [BW-1:0] b,
                                     output logic [BW-1:0] r, output logic h, output logic s);
        logic [2:0] lr;
        logic lh, ls;
        h = 0; s = 0; r = '0;
        for (int i = 0; i < LINES; i++) begin
            ref_line(a[i*3 +: 3], b[i*3 +: 3], lr, lh, ls);
            r[i*3 +: 3] = lr;
            h = h | lh;
            s = s | ls;
        end
    endfunction

    task automatic check(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply one cube pair and check the result on the strobe cycle
    task automatic run_pair(input string req, input logic [BW-1:0] a, input logic [BW-1:0] b);
        logic [BW-1:0] er;
        logic eh, es;
        ref_cube(a, b, er, eh, es);
        @(negedge clk);
        cube_a = a; cube_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({req, " valid R7"}, BW'(out_valid), BW'(1));
        check({req, " hard"}, BW'(hard_fail), BW'(eh));
        check({req, " soft"}, BW'(soft_fail), BW'(es));
        if (!eh && !es) check({req, " cube R6"}, cube_out, er);
    endtask

    function automatic logic [BW-1:0] all_x();
        logic [BW-1:0] v;
        for (int i = 0; i < LINES; i++) v[i*3 +: 3] = 3'b010;
        return v;
    endfunction

    initial begin
        logic [BW-1:0] a, b;
        logic eh, es;
        logic [BW-1:0] er;
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 valid", BW'(out_valid), '0);
        check("R8 hard", BW'(hard_fail), '0);
        check("R8 soft", BW'(soft_fail), '0);
        rst = 1'b0;

        // R1 R2 R3 R4: all 25 pairs on line 0
        for (int x = 0; x < 5; x++) begin
            for (int y = 0; y < 5; y++) begin
                a = all_x(); b = all_x();
                a[2:0] = 3'(x); b[2:0] = 3'(y);
                run_pair("R1/R2/R3/R4 pair", a, b);
            end
        end

        // R5: undefined codes on either side
        for (int c = 5; c < 8; c++) begin
            a = all_x(); b = all_x();
            a[17:15] = 3'(c);
            run_pair("R5 undefined a", a, b);
            a = all_x(); b[17:15] = 3'(c); b[20:18] = 3'b001;
            run_pair("R5 undefined b", a, b);
        end

        // R6: clash on top line only; both kinds in one cube
        a = all_x(); b = all_x();
        a[BW-1 -: 3] = 3'b001; b[BW-1 -: 3] = 3'b000;
        run_pair("R6 top hard", a, b);
        a[2:0] = 3'b011; b[2:0] = 3'b100;
        run_pair("R6 both", a, b);
        check("R6 both flags", BW'({hard_fail, soft_fail}), BW'(2'b11));

        // R7: hold and single-cycle strobe
        @(negedge clk);
        check("R7 strobe low", BW'(out_valid), '0);
        check("R7 hold hard", BW'(hard_fail), BW'(1));
        check("R7 hold soft", BW'(soft_fail), BW'(1));

        // Random cubes
        for (int t = 0; t < 300; t++) begin
            for (int i = 0; i < LINES; i++) begin
                logic [2:0] base;
                int pick;
                base = 3'($urandom_range(0, 4));
                a[i*3 +: 3] = ($urandom_range(0, 3) == 0) ? 3'b010 : base;
                pick = $urandom_range(0, 19);
                if (pick < 8) b[i*3 +: 3] = 3'b010;
                else if (pick < 18) b[i*3 +: 3] = base;
                else b[i*3 +: 3] = 3'($urandom_range(0, 7));
            end
            if (t % 3 == 0) begin
                // R9: back-to-back start, checked cycle by cycle
                ref_cube(a, b, er, eh, es);
                @(negedge clk);
                cube_a = a; cube_b = b; start = 1'b1;
                @(negedge clk);
                cube_a = b; cube_b = a;
                check("R9 first valid", BW'(out_valid), BW'(1));
                check("R9 first flags", BW'({hard_fail, soft_fail}), BW'({eh, es}));
                if (!eh && !es) check("R9 first cube", cube_out, er);
                ref_cube(b, a, er, eh, es);
                @(negedge clk);
                start = 1'b0;
                check("R9 second valid", BW'(out_valid), BW'(1));
                check("R9 second flags", BW'({hard_fail, soft_fail}), BW'({eh, es}));
                if (!eh && !es) check("R9 second cube", cube_out, er);
            end else begin
                run_pair("R1/R2/R6 random", a, b);
            end
        end

        // R8: reset mid-run clears flags
        a = all_x(); b = all_x(); a[5:3] = 3'b000; b[5:3] = 3'b001;
        run_pair("R3 pre-reset", a, b);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R8 cleared", BW'({out_valid, hard_fail, soft_fail}), '0);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule